// File: doc/BRIEF.md
# Single-Line External Interrupt Controller

This block watches one external interrupt wire, for example the request line of a power-management companion chip. It turns activity on that wire into a latched pending flag and raises one interrupt request toward the upstream interrupt controller. The pin is first brought into the clock domain by a short flop chain. A two-bit trigger selection then picks which condition counts as an event: a low level, a high level, a falling edge or a rising edge.

Software uses a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Through it, software chooses the trigger, enables or masks the request, and acknowledges the pending flag. The request output comes only from the latched flag gated by the enable bit, so a handler that reads the flag never finds it clear while the request is high. A build-time parameter places the three registers at one of three address layouts. The block serves a single source, index 0.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset the trigger field, the pending flag and the enable bit all read 0, and `irq_out` is low. The synchronizer starts at the idle-high level, so the reset trigger (low level) sees no event while the pin stays high.
- R2: The parameter `LAYOUT` places the registers as trigger/pending/enable at offsets 0x00/0x04/0x08 when it is 0, at 0x00/0x04/0x34 when it is 1, and at 0x0C/0x10/0x40 when it is 2. Any other address reads as 0 and ignores writes.
- R3: The trigger register holds the mode in bits [1:0] and reads it back there. The codes are 0 for low level, 1 for falling edge, 2 for high level and 3 for rising edge. The mode changes only on a write to that register.
- R4: The pin passes through two synchronizing flops. A pin change made just after a clock edge shows in the pending flag, and in `irq_out`, after the third following rising edge and not earlier.
- R5: In an edge mode, one transition of the selected direction sets pending once. Pending stays set after the pin returns, until it is acknowledged.
- R6: In a level mode, pending is set again on every cycle in which the synchronized pin is at the active level. An acknowledge therefore clears it only once the level has gone away.
- R7: Writing 1 to bit 0 of the pending register clears the flag when no event arrives in the same cycle. Writing 0 there leaves it unchanged.
- R8: Bit 0 of the enable register gates the request: `irq_out` equals pending AND enable. Writing 0 drops `irq_out` on the next edge and keeps pending set.
- R9: When an acknowledge write and a new event fall in the same cycle, the event wins and pending stays set.
- R10: `irq_out` is never high while the pending flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 1 | External interrupt wire, asynchronous |
| irq_out | output | 1 | Interrupt request to the upstream controller |

## Verification
A wrong trigger decode or a synchronizer of the wrong length shows at `irq_out`. The request would rise one cycle early or late against the fixed three-edge latency, or it would not rise at all for the selected direction. A pending flag that obeys the acknowledge over a live event shows on the next register read as 0 while the level is still present or the edge has just arrived. A stale enable leaves the request high one edge after a masking write. Every such fault is visible at the ports within one to three cycles of the stimulus that exposes it.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int unsigned REG_W = 32;

    // Trigger selection, encoded as software writes it
    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'd0,
        TRIG_FALL   = 2'd1,
        TRIG_LVL_HI = 2'd2,
        TRIG_RISE   = 2'd3
    } trig_e;

    // Byte offsets of the three registers
    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] pend;
        logic [7:0] en;
    } reg_map_t;

    // One-hot register select decoded from the address
    typedef struct packed {
        logic ctrl;
        logic pend;
        logic en;
    } reg_sel_t;

    function automatic reg_map_t map_of(input int unsigned layout);
        reg_map_t m;
        case (layout)
            1:       m = '{ctrl: 8'h00, pend: 8'h04, en: 8'h34};
            2:       m = '{ctrl: 8'h0C, pend: 8'h10, en: 8'h40};
            default: m = '{ctrl: 8'h00, pend: 8'h04, en: 8'h08};
        endcase
        return m;
    endfunction

    // Event condition for the current and previous synchronized samples
    function automatic logic trig_hit(input trig_e mode, input logic cur, input logic prev);
        logic hit;
        case (mode)
            TRIG_LVL_LO: hit = !cur;
            TRIG_FALL:   hit = prev && !cur;
            TRIG_LVL_HI: hit = cur;
            default:     hit = !prev && cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic cur,
    output logic prev
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE_VAL}};
            prev_q  <= IDLE_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_in};
            prev_q  <= chain_q[TOP];
        end
    end

    assign cur  = chain_q[TOP];
    assign prev = prev_q;

    // Edge-history sample trails the output stage by exactly one cycle
    AST_PREV_TRAILS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prev == $past(cur))) else $error("prev sample lag"); // R4

endmodule

// File: rtl/sirq_detect.sv
module sirq_detect
    import sirq_pkg::*;
(
    input  trig_e mode,
    input  logic  cur,
    input  logic  prev,
    output logic  evt
);
    always_comb begin
        evt = trig_hit(mode, cur, prev);
    end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int unsigned LAYOUT = 0,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              evt,
    output trig_e             mode,
    output logic              pend,
    output logic              en,
    output logic [REG_W-1:0]  rdata
);
    localparam reg_map_t MAP = map_of(LAYOUT);

    reg_sel_t sel;
    trig_e    mode_q;
    logic     pend_q;
    logic     en_q;
    logic     ack_w;
    logic     unused_wdata;

    assign unused_wdata = &{1'b0, bus_wdata[REG_W-1:2]};

    always_comb begin
        sel.ctrl = (bus_addr == ADDR_W'(MAP.ctrl));
        sel.pend = (bus_addr == ADDR_W'(MAP.pend));
        sel.en   = (bus_addr == ADDR_W'(MAP.en));
    end

    assign ack_w = bus_we && sel.pend && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TRIG_LVL_LO;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (bus_we && sel.ctrl) mode_q <= trig_e'(bus_wdata[1:0]);
            if (bus_we && sel.en)   en_q   <= bus_wdata[0];
            if (evt)                pend_q <= 1'b1;
            else if (ack_w)         pend_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel.ctrl) rdata[1:0] = mode_q;
        if (sel.pend) rdata[0]   = pend_q;
        if (sel.en)   rdata[0]   = en_q;
    end

    assign mode = mode_q;
    assign pend = pend_q;
    assign en   = en_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_w && !evt) |=> !pend_q) else $error("ack did not clear"); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend_q) else $error("event lost"); // R9
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!evt && !ack_w) |=> $stable(pend_q)) else $error("pending moved"); // R5
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && sel.ctrl) |=> $stable(mode_q)) else $error("mode moved"); // R3

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int unsigned LAYOUT      = 0,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pin_in,
    output logic              irq_out
);
    localparam reg_map_t MAP     = map_of(LAYOUT);
    localparam logic     PIN_IDLE = 1'b1;

    logic  s_cur;
    logic  s_prev;
    logic  evt;
    trig_e mode;
    logic  pend;
    logic  en;

    sirq_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_in(pin_in),
        .cur   (s_cur),
        .prev  (s_prev)
    );

    sirq_detect u_detect (
        .mode(mode),
        .cur (s_cur),
        .prev(s_prev),
        .evt (evt)
    );

    sirq_regs #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .evt      (evt),
        .mode     (mode),
        .pend     (pend),
        .en       (en),
        .rdata    (bus_rdata)
    );

    assign irq_out = pend && en;

    AST_MASK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(MAP.en) && !bus_wdata[0]) |=> !irq_out)
        else $error("mask write left request high"); // R8

endmodule

// File: tb/tb_sirq_ctrl.sv
`timescale 1ns/1ps
module tb_sirq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        we_a = 1'b0;
    logic        we_b = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        pin = 1'b1;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;

    int unsigned total = 0;
    int unsigned bad   = 0;
    bit          done  = 0;

    // scoreboard queues: kind 0 = rdata of dut, 1 = rdata of dut2, 2 = irq of dut
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sirq_ctrl #(.LAYOUT(0)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_a),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pin_in(pin), .irq_out(irq_a)
    );

    sirq_ctrl #(.LAYOUT(2)) dut2 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(we_b),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin), .irq_out(irq_b)
    );

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_PEND = 8'h04;
    localparam logic [7:0] A_EN   = 8'h08;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drivers: called at a falling edge
    task automatic wr(input bit second, input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        if (second) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
    endtask

    task automatic rd(input bit second, input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        kind_q.push_back(second ? 1 : 0);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic irq_is(input logic e, input string tag);
        kind_q.push_back(2);
        exp_q.push_back({31'b0, e});
        tag_q.push_back(tag);
    endtask

    // monitor: compares away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (kind_q.size() > 0) begin
                int          k;
                logic [31:0] e;
                logic [31:0] act;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = (k == 0) ? rdata_a : (k == 1) ? rdata_b : {31'b0, irq_a};
                total++;
                if (act !== e) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, act, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(2);
        // R1 reset state
        rd(0, A_CTRL, 32'h0, "R1 ctrl"); irq_is(1'b0, "R1 irq"); step(1);
        rd(0, A_PEND, 32'h0, "R1 pend"); step(1);
        rd(0, A_EN,   32'h0, "R1 en");   step(1);

        // R2 layouts: dut2 enable at 0x40, 0x08 unmapped there; 0x40 unmapped on dut
        wr(1, 8'h40, 32'h1);
        rd(1, 8'h40, 32'h1, "R2 layout2 en"); step(1);
        rd(1, 8'h08, 32'h0, "R2 layout2 unmapped"); step(1);
        wr(0, 8'h40, 32'h1);
        rd(0, A_EN, 32'h0, "R2 unmapped write ignored"); step(1);
        wr(1, 8'h0C, 32'h3);
        rd(1, 8'h0C, 32'h3, "R2 layout2 ctrl"); step(1);

        // R3 rising mode readback, enable
        wr(0, A_CTRL, 32'hFFFF_FFF3);
        rd(0, A_CTRL, 32'h3, "R3 ctrl readback"); step(1);
        wr(0, A_EN, 32'h1);
        pin = 1'b0; step(5);
        rd(0, A_PEND, 32'h0, "R5 falling ignored in rising mode"); step(1);

        // R4 latency
        pin = 1'b1;
        step(2); irq_is(1'b0, "R4 not before third edge");
        step(1); irq_is(1'b1, "R4 third edge");
        rd(0, A_PEND, 32'h1, "R5 rising sets"); step(1);
        pin = 1'b0; step(5);
        rd(0, A_PEND, 32'h1, "R5 held after pin returns"); step(1);

        // R7 acknowledge
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h0, "R7 ack clears"); irq_is(1'b0, "R10 no request without pending");
        step(1);
        pin = 1'b1; step(4);
        wr(0, A_PEND, 32'h0);
        rd(0, A_PEND, 32'h1, "R7 write 0 no effect"); step(1);
        wr(0, A_PEND, 32'h1);

        // R3 falling mode
        wr(0, A_CTRL, 32'h1);
        step(2);
        rd(0, A_PEND, 32'h0, "R3 mode switch no event"); step(1);
        pin = 1'b0; step(4);
        rd(0, A_PEND, 32'h1, "R3 falling sets"); irq_is(1'b1, "R8 enabled request"); step(1);

        // R8 gating
        wr(0, A_EN, 32'h0);
        irq_is(1'b0, "R8 mask drops request"); rd(0, A_PEND, 32'h1, "R8 pending kept"); step(1);
        wr(0, A_EN, 32'h1);
        irq_is(1'b1, "R8 unmask restores");
        wr(0, A_PEND, 32'h1);
        irq_is(1'b0, "R8 ack drops request");

        // R6 high level
        wr(0, A_CTRL, 32'h2);
        pin = 1'b1; step(4);
        rd(0, A_PEND, 32'h1, "R6 high level sets"); step(1);
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h1, "R6 ack ignored while high");
        pin = 1'b0; step(4);
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h0, "R6 ack after level gone"); step(1);

        // R6 low level
        wr(0, A_CTRL, 32'h0);
        step(1);
        rd(0, A_PEND, 32'h1, "R6 low level sets"); step(1);
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h1, "R6 ack ignored while low"); step(1);
        pin = 1'b1; step(4);
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h0, "R6 low level released"); irq_is(1'b0, "R10 idle"); step(1);

        // R9 ack colliding with a new rising edge
        wr(0, A_CTRL, 32'h3);
        pin = 1'b0; step(4);
        pin = 1'b1; step(4);
        pin = 1'b0; step(4);
        rd(0, A_PEND, 32'h1, "R9 setup pending"); step(1);
        pin = 1'b1; step(2);
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h1, "R9 event beats ack"); step(1);
        wr(0, A_PEND, 32'h1);
        rd(0, A_PEND, 32'h0, "R9 plain ack after"); step(1);

        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule